// File: doc/BRIEF.md
# Cable Connection Debouncer with Bus-Reset Trigger

This block watches the raw "cable connected" indication of each of three ports and turns it into a clean per-port link status. Connecting and disconnecting are treated differently. A new connection counts only after the raw signal has stayed high for a long, uninterrupted stability window. A disconnect takes effect at once. Whenever any port's accepted status changes, the block raises a single-cycle request asking the surrounding logic to start a bus reset.

The block also drives an undebounced "no cable active" flag. This flag is high whenever none of the ports currently sees a cable, so power management can act on it without waiting for the stability window. The window length is a parameter counted in clock cycles. Its default corresponds to 335 ms at a 49.152 MHz clock (16,465,920 cycles), and a bench can pass a small value.

Top module: `cable_link_watch`

## Requirements
- R1: Once a port's raw input rises and then stays high, that port's `link_up` bit rises exactly DEBOUNCE_CYCLES+2 clock edges after the first edge that sees the input high. Two of those edges are synchronizer stages and DEBOUNCE_CYCLES are stable-count edges.
- R2: When a port's raw input falls, its `link_up` bit clears on the third clock edge after the change, with no stability wait.
- R3: On every clock edge where any `link_up` bit changes, `bus_reset_req` is high for that one cycle and low on the following cycle if nothing else changes.
- R4: While `rst` is high, `link_up` is 0, `bus_reset_req` is 0 and `no_cable` is 1. After reset, a raw input that was already high is treated as a new connection, so it is accepted after the R1 delay and triggers a bus-reset request.
- R5: `no_cable` is 1 exactly when every synchronized raw input is low. It follows the raw inputs two edges after a change and is not debounced: it drops while `link_up` is still 0 and rises before `link_up` has cleared.
- R6: If a raw input drops during the stability window, that port's count restarts. The port is then accepted DEBOUNCE_CYCLES+2 edges after its last rise, and no bus-reset request is raised during the aborted attempt.
- R7: When several ports change status on the same edge, `bus_reset_req` is a single one-cycle pulse. It is high only on edges where some `link_up` bit changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_conn | input | 3 | Raw per-port cable-present indication, asynchronous |
| link_up | output | 3 | Debounced per-port connection status |
| bus_reset_req | output | 1 | One-cycle request to start a bus reset |
| no_cable | output | 1 | High when no port sees a cable (undebounced) |

## Verification
Each result has a fixed latency after the bench changes `raw_conn` just after a rising edge. `no_cable` is due two edges later. A cleared `link_up` bit is due three edges later. An accepted connection and its `bus_reset_req` pulse are due DEBOUNCE_CYCLES+2 edges later, and the pulse is gone one edge after that. Every check waits the exact number of rising edges and samples one time unit after the edge. Each check also looks one edge early, to show the output has not yet moved, so a block that is early or late by one cycle is caught.

// File: rtl/cable_dbnc_pkg.sv
package cable_dbnc_pkg;

  // Width of a counter that must hold values 0 .. limit-1.
  function automatic int unsigned span_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  // Total edges from a raw rise to acceptance: two sync stages plus the window.
  function automatic int unsigned accept_latency(input int unsigned limit);
    return limit + 2;
  endfunction

endpackage

// File: rtl/conn_sync2.sv
module conn_sync2 #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q_sync <= '0;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/port_stability_timer.sv
module port_stability_timer
  import cable_dbnc_pkg::*;
#(
  parameter int unsigned LIMIT = 16465920
) (
  input  logic clk,
  input  logic rst,
  input  logic conn_s,
  output logic link,
  output logic change_evt
);
  localparam int unsigned CW = span_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] stable_cnt;
  logic          accept_now;
  logic          drop_now;

  always_comb begin
    accept_now = conn_s && !link && (stable_cnt == LAST);
    drop_now   = !conn_s && link;
    change_evt = accept_now || drop_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link       <= 1'b0;
      stable_cnt <= '0;
    end else if (!conn_s) begin
      link       <= 1'b0;
      stable_cnt <= '0;
    end else if (!link) begin
      if (accept_now) begin
        link       <= 1'b1;
        stable_cnt <= '0;
      end else begin
        stable_cnt <= stable_cnt + 1'b1;
      end
    end
  end

  assert_connect_stable_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(link) |-> (conn_s && $past(conn_s)));

  assert_drop_immediate_R2: assert property (@(posedge clk) disable iff (rst)
    !conn_s |=> !link);

  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    stable_cnt <= LAST);

  assert_restart_on_drop_R6: assert property (@(posedge clk) disable iff (rst)
    !conn_s |=> (stable_cnt == '0));
endmodule

// File: rtl/cable_link_watch.sv
module cable_link_watch
  import cable_dbnc_pkg::*;
#(
  parameter int unsigned NPORTS          = 3,
  parameter int unsigned DEBOUNCE_CYCLES = 16465920
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] raw_conn,
  output logic [NPORTS-1:0] link_up,
  output logic              bus_reset_req,
  output logic              no_cable
);
  logic [NPORTS-1:0] conn_s;
  logic [NPORTS-1:0] port_evt;

  conn_sync2 #(.WIDTH(NPORTS)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_conn),
    .q_sync  (conn_s)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    port_stability_timer #(.LIMIT(DEBOUNCE_CYCLES)) i_timer (
      .clk        (clk),
      .rst        (rst),
      .conn_s     (conn_s[p]),
      .link       (link_up[p]),
      .change_evt (port_evt[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) bus_reset_req <= 1'b0;
    else     bus_reset_req <= |port_evt;
  end

  assign no_cable = ~|conn_s;

  assert_reset_clear_R4: assert property (@(posedge clk)
    rst |=> ((link_up == '0) && !bus_reset_req));

  assert_req_on_change_R3: assert property (@(posedge clk) disable iff (rst)
    (link_up != $past(link_up)) |-> bus_reset_req);

  assert_req_only_on_change_R7: assert property (@(posedge clk) disable iff (rst)
    bus_reset_req |-> (link_up != $past(link_up)));

  assert_nocable_clears_links_R5: assert property (@(posedge clk) disable iff (rst)
    no_cable |=> (link_up == '0));
endmodule

// File: tb/test_cable_link_watch.sv
module test_cable_link_watch;
  localparam int unsigned L = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] raw_conn = 3'b000;
  logic [2:0] link_up;
  logic       bus_reset_req;
  logic       no_cable;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cable_link_watch #(.NPORTS(3), .DEBOUNCE_CYCLES(L)) i_cable_link_watch (
    .clk           (clk),
    .rst           (rst),
    .raw_conn      (raw_conn),
    .link_up       (link_up),
    .bus_reset_req (bus_reset_req),
    .no_cable      (no_cable)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic t_reset_R4;
    raw_conn = 3'b001;
    edges(3);
    chk(link_up == 3'b000, "R4", "link_up in reset", link_up, 0);
    chk(bus_reset_req == 1'b0, "R4", "req in reset", bus_reset_req, 0);
    chk(no_cable == 1'b1, "R4", "no_cable in reset", no_cable, 1);
    rst = 1'b0;
    edges(L + 1);
    chk(link_up == 3'b000, "R4", "link before window", link_up, 0);
    edges(1);
    chk(link_up == 3'b001, "R4", "link after window", link_up, 3'b001);
    chk(bus_reset_req == 1'b1, "R4", "req after reset connect", bus_reset_req, 1);
    edges(1);
    chk(bus_reset_req == 1'b0, "R3", "req single cycle", bus_reset_req, 0);
  endtask

  task automatic t_connect_R1;
    raw_conn = 3'b011;
    edges(L + 1);
    chk(link_up == 3'b001, "R1", "port1 not yet accepted", link_up, 3'b001);
    chk(bus_reset_req == 1'b0, "R3", "no early req", bus_reset_req, 0);
    edges(1);
    chk(link_up == 3'b011, "R1", "port1 accepted", link_up, 3'b011);
    chk(bus_reset_req == 1'b1, "R3", "req on connect", bus_reset_req, 1);
    edges(1);
    chk(bus_reset_req == 1'b0, "R3", "req drops", bus_reset_req, 0);
  endtask

  task automatic t_disconnect_R2;
    raw_conn = 3'b001;
    edges(2);
    chk(link_up == 3'b011, "R2", "port1 still up at edge 2", link_up, 3'b011);
    edges(1);
    chk(link_up == 3'b001, "R2", "port1 down at edge 3", link_up, 3'b001);
    chk(bus_reset_req == 1'b1, "R3", "req on disconnect", bus_reset_req, 1);
    edges(1);
    chk(bus_reset_req == 1'b0, "R3", "req drops", bus_reset_req, 0);
  endtask

  task automatic t_glitch_R6;
    logic saw_req;
    saw_req = 1'b0;
    raw_conn = 3'b101;
    for (int i = 0; i < 6; i++) begin
      edges(1);
      saw_req |= bus_reset_req;
    end
    raw_conn = 3'b001;
    for (int i = 0; i < 3; i++) begin
      edges(1);
      saw_req |= bus_reset_req;
    end
    chk(saw_req == 1'b0, "R6", "no req during aborted attempt", saw_req, 0);
    chk(link_up == 3'b001, "R6", "port2 not accepted", link_up, 3'b001);
    raw_conn = 3'b101;
    edges(L + 1);
    chk(link_up == 3'b001, "R6", "restarted window not done", link_up, 3'b001);
    edges(1);
    chk(link_up == 3'b101, "R6", "accepted after full window", link_up, 3'b101);
    chk(bus_reset_req == 1'b1, "R6", "req on accept", bus_reset_req, 1);
    edges(1);
  endtask

  task automatic t_all_R5_R7;
    raw_conn = 3'b000;
    edges(1);
    chk(no_cable == 1'b0, "R5", "no_cable before sync", no_cable, 0);
    edges(1);
    chk(no_cable == 1'b1, "R5", "no_cable at edge 2", no_cable, 1);
    chk(link_up == 3'b101, "R5", "links still up (undebounced flag)", link_up, 3'b101);
    edges(1);
    chk(link_up == 3'b000, "R7", "both dropped", link_up, 0);
    chk(bus_reset_req == 1'b1, "R7", "one req for two drops", bus_reset_req, 1);
    edges(1);
    chk(bus_reset_req == 1'b0, "R7", "req single cycle", bus_reset_req, 0);
    raw_conn = 3'b011;
    edges(2);
    chk(no_cable == 1'b0, "R5", "no_cable drops before debounce", no_cable, 0);
    chk(link_up == 3'b000, "R5", "links still down", link_up, 0);
    edges(L - 1);
    chk(bus_reset_req == 1'b0, "R7", "no early req", bus_reset_req, 0);
    edges(1);
    chk(link_up == 3'b011, "R7", "two ports accepted together", link_up, 3'b011);
    chk(bus_reset_req == 1'b1, "R7", "single req", bus_reset_req, 1);
    edges(1);
    chk(bus_reset_req == 1'b0, "R7", "req one cycle", bus_reset_req, 0);
  endtask

  initial begin
    t_reset_R4();
    t_connect_R1();
    t_disconnect_R2();
    t_glitch_R6();
    t_all_R5_R7();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule